// File: doc/BRIEF.md
# Port-Mapped Static RAM with Auto-Increment Pointer

This block is a byte-wide static RAM card for an 8-bit processor bus, reached only through I/O ports. The processor cannot address the storage directly. It first loads a 16-bit pointer one byte at a time through two ports. It then moves data through a single data port, and the pointer steps forward by one after every data transfer. Long blocks of bytes can therefore be copied in or out with a tight loop of port instructions.

The port map is not symmetric. A read of the pointer-high port clears the pointer instead of returning it. The pointer-low port acts as the data-out port when it is read. A read-only input models a card backed by fixed contents: data writes are then discarded, but they still move the pointer.

The full card holds 32768 bytes (`IDX_W` = 15). The default build uses `IDX_W` = 11 so that the elaborated array stays small. In both cases only the low `IDX_W` pointer bits select a byte.

Top module: `portsram_top`

## Requirements
- R1: After reset the pointer is 0x0000 and every storage byte reads as 0x00.
- R2: A write strobe with port address 0xF8 loads the data byte into pointer bits 15:8 and leaves bits 7:0 unchanged.
- R3: A write strobe with port address 0xF9 loads the data byte into pointer bits 7:0 and leaves bits 15:8 unchanged.
- R4: A write strobe with port address 0xFA stores the data byte at the byte the pointer selects, and the pointer then increases by one.
- R5: While readOnly is 1, a write strobe to port 0xFA leaves the storage unchanged but still increases the pointer by one.
- R6: A read strobe with port address 0xF9 presents the selected byte on rdData in the same cycle, and the pointer increases by one at the next clock edge, so consecutive reads return consecutive bytes.
- R7: A read strobe with port address 0xF8 returns 0xFF and sets the pointer to 0x0000.
- R8: rdData is 0xFF in every cycle without a read strobe on port 0xF9. Reads of any other port, 0xFA included, and writes to ports other than 0xF8, 0xF9 and 0xFA change neither the pointer nor the storage.
- R9: Only pointer bits IDX_W-1:0 select the storage byte, so pointers that differ only in higher bits reach the same byte.
- R10: The pointer is 16 bits wide and wraps from 0xFFFF to 0x0000 when it increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| portAddr | input | 8 | Low byte of the I/O port address |
| wrStrobe | input | 1 | One-cycle port write request |
| rdStrobe | input | 1 | One-cycle port read request |
| wrData | input | 8 | Byte written to the port |
| readOnly | input | 1 | 1 discards data-port writes to the storage |
| rdData | output | 8 | Byte returned for the port read in this cycle |
| ptrQ | output | 16 | Current pointer value |

## Verification
The assertions assume that read and write strobes are never high in the same cycle, since a bus cycle is either one or the other. One property checks this assumption on the inputs. The bench drives each port access as a single strobe lasting exactly one cycle, with the port address and data held steady across that cycle, so the assumption always holds. The bench also keeps track of readOnly so that it drops only the writes R5 says must be dropped. The full storage is swept with a computed pattern. The storage is observed only through the data port.

// File: rtl/portsram_pkg.sv
package portsram_pkg;

  // Strobes from the port decoder to the pointer/storage datapath
  typedef struct packed {
    logic loadHi;   // replace pointer high byte
    logic loadLo;   // replace pointer low byte
    logic clrPtr;   // force pointer to zero
    logic incPtr;   // advance pointer by one
    logic memWr;    // commit data byte into storage
    logic memRd;    // drive selected byte onto read bus
  } ctlStrobes_t;

endpackage

// File: rtl/portsram_ctrl.sv
module portsram_ctrl
  import portsram_pkg::*;
#(
  parameter int         PA_W      = 8,
  parameter logic [7:0] PORT_HI   = 8'hF8,
  parameter logic [7:0] PORT_LO   = 8'hF9,
  parameter logic [7:0] PORT_DATA = 8'hFA
) (
  input  logic [PA_W-1:0] portAddr,
  input  logic            wrStrobe,
  input  logic            rdStrobe,
  input  logic            readOnly,
  output ctlStrobes_t     ctl
);

  logic hitHi, hitLo, hitData;

  assign hitHi   = (portAddr == PA_W'(PORT_HI));
  assign hitLo   = (portAddr == PA_W'(PORT_LO));
  assign hitData = (portAddr == PA_W'(PORT_DATA));

  always_comb begin
    ctl = '0;
    if (wrStrobe) begin
      ctl.loadHi = hitHi;
      ctl.loadLo = hitLo;
      ctl.memWr  = hitData && !readOnly;
      ctl.incPtr = hitData;
    end else if (rdStrobe) begin
      ctl.clrPtr = hitHi;
      ctl.memRd  = hitLo;
      ctl.incPtr = hitLo;
    end
  end

endmodule

// File: rtl/portsram_datapath.sv
module portsram_datapath
  import portsram_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [PTR_W-1:0]  ptrQ,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int HALF_W = PTR_W / 2;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [IDX_W-1:0]  memIdx;
  logic [PTR_W-1:0]  ptrNext;

  assign memIdx = ptrQ[IDX_W-1:0];

  always_comb begin
    ptrNext = ptrQ;
    if (ctl.clrPtr)      ptrNext = '0;
    else if (ctl.loadHi) ptrNext = {wrData[HALF_W-1:0], ptrQ[HALF_W-1:0]};
    else if (ctl.loadLo) ptrNext = {ptrQ[PTR_W-1:HALF_W], wrData[HALF_W-1:0]};
    else if (ctl.incPtr) ptrNext = ptrQ + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptrQ <= '0;
    else       ptrQ <= ptrNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
    end else if (ctl.memWr) begin
      memArr[memIdx] <= wrData;
    end
  end

  assign rdData = ctl.memRd ? memArr[memIdx] : '1;

endmodule

// File: rtl/portsram_top.sv
module portsram_top
  import portsram_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 11,
  parameter int PA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PA_W-1:0]   portAddr,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              readOnly,
  output logic [DATA_W-1:0] rdData,
  output logic [PTR_W-1:0]  ptrQ
);

  ctlStrobes_t ctl;

  portsram_ctrl #(.PA_W(PA_W)) u_ctrl (
    .portAddr (portAddr),
    .wrStrobe (wrStrobe),
    .rdStrobe (rdStrobe),
    .readOnly (readOnly),
    .ctl      (ctl)
  );

  portsram_datapath #(.PTR_W(PTR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wrData (wrData),
    .ptrQ   (ptrQ),
    .rdData (rdData)
  );

endmodule

// File: rtl/portsram_checker.sv
module portsram_checker #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8,
  parameter int PA_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [PA_W-1:0]   portAddr,
  input logic              wrStrobe,
  input logic              rdStrobe,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [PTR_W-1:0]  ptrQ
);

  localparam int HALF_W = PTR_W / 2;

  logic atHi, atLo, atData;
  assign atHi   = (portAddr == PA_W'(8'hF8));
  assign atLo   = (portAddr == PA_W'(8'hF9));
  assign atData = (portAddr == PA_W'(8'hFA));

  // input assumption: one bus cycle type at a time
  p_excl_strobes_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && rdStrobe));

  p_load_hi_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && atHi) |=>
      (ptrQ[PTR_W-1:HALF_W] == $past(wrData[HALF_W-1:0])) &&
      (ptrQ[HALF_W-1:0] == $past(ptrQ[HALF_W-1:0])));

  p_load_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && atLo) |=>
      (ptrQ[HALF_W-1:0] == $past(wrData[HALF_W-1:0])) &&
      (ptrQ[PTR_W-1:HALF_W] == $past(ptrQ[PTR_W-1:HALF_W])));

  // covers readOnly too (R5) and wrap (R10)
  p_wr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && atData) |=> ptrQ == PTR_W'($past(ptrQ) + PTR_W'(1)));

  p_rd_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && atLo) |=> ptrQ == PTR_W'($past(ptrQ) + PTR_W'(1)));

  p_rd_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && atHi) |=> ptrQ == '0);

  p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && atLo) |-> rdData == '1);

  p_other_rd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !atHi && !atLo) |=> $stable(ptrQ));

  p_other_wr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !atHi && !atLo && !atData) |=> $stable(ptrQ));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStrobe && !rdStrobe) |=> $stable(ptrQ));

endmodule

bind portsram_top portsram_checker #(.PTR_W(PTR_W), .DATA_W(DATA_W), .PA_W(PA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .portAddr (portAddr),
  .wrStrobe (wrStrobe),
  .rdStrobe (rdStrobe),
  .wrData   (wrData),
  .rdData   (rdData),
  .ptrQ     (ptrQ)
);

// File: tb/tb_portsram_top.sv
module tb_portsram_top;

  localparam int IDX_W = 11;
  localparam int DEPTH = 1 << IDX_W;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] portAddr = 8'h00;
  logic       wrStrobe = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       readOnly = 1'b0;
  logic [7:0] rdData;
  logic [15:0] ptrQ;

  int checks = 0;
  int failures = 0;

  logic [7:0]  model [DEPTH];
  logic [15:0] mPtr;

  always #10 clk = ~clk;  // 50 MHz

  portsram_top dut (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe), .wrData(wrData), .readOnly(readOnly),
    .rdData(rdData), .ptrQ(ptrQ)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one-cycle port write, model updated per R2..R5, R8..R10
  task automatic portWr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    portAddr = a; wrData = d; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
    case (a)
      8'hF8: mPtr = {d, mPtr[7:0]};
      8'hF9: mPtr = {mPtr[15:8], d};
      8'hFA: begin
        if (!readOnly) model[mPtr[IDX_W-1:0]] = d;
        mPtr = mPtr + 16'd1;
      end
      default: ;
    endcase
  endtask

  // one-cycle port read, data sampled mid-cycle, checked against model
  task automatic portRd(input string tag, input logic [7:0] a);
    logic [7:0] exp;
    @(negedge clk);
    portAddr = a; rdStrobe = 1'b1;
    #5;
    exp = (a == 8'hF9) ? model[mPtr[IDX_W-1:0]] : 8'hFF;
    check8(tag, rdData, exp);
    @(negedge clk);
    rdStrobe = 1'b0;
    if (a == 8'hF9) mPtr = mPtr + 16'd1;
    else if (a == 8'hF8) mPtr = 16'h0000;
  endtask

  task automatic setPtr(input logic [15:0] p);
    portWr(8'hF9, p[7:0]);
    portWr(8'hF8, p[15:8]);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    mPtr = 16'h0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state; R8: idle read bus
    #5 check8("R1 ptr lo", ptrQ[7:0], 8'h00);
    check8("R1 ptr hi", ptrQ[15:8], 8'h00);
    check8("R8 idle rdData", rdData, 8'hFF);
    for (int i = 0; i < 16; i++) portRd("R1 zero fill", 8'hF9);

    // R4/R6: full sweep write then stream read
    setPtr(16'h0000);
    for (int i = 0; i < DEPTH; i++) portWr(8'hFA, 8'((i * 7 + 3) & 8'hFF));
    setPtr(16'h0000);
    for (int i = 0; i < DEPTH; i++) portRd("R6 stream read", 8'hF9);

    // R2/R3: byte-wise pointer loads
    setPtr(16'h0210);
    portWr(8'hF8, 8'h03);           // -> 0x0310
    portWr(8'hFA, 8'hA5);
    setPtr(16'h0310);
    portRd("R2 hi keeps lo", 8'hF9);
    setPtr(16'h0210);
    portRd("R2 old loc untouched", 8'hF9);
    setPtr(16'h0455);
    portWr(8'hF9, 8'h66);           // -> 0x0466
    portWr(8'hFA, 8'h3C);
    setPtr(16'h0466);
    portRd("R3 lo keeps hi", 8'hF9);

    // R5: read-only drops writes, pointer still advances
    setPtr(16'h0010);
    readOnly = 1'b1;
    portWr(8'hFA, 8'h00);
    portWr(8'hFA, 8'h11);
    readOnly = 1'b0;
    portWr(8'hFA, 8'h77);           // lands at 0x0012
    setPtr(16'h0010);
    portRd("R5 ro byte0", 8'hF9);
    portRd("R5 ro byte1", 8'hF9);
    portRd("R5 step kept", 8'hF9);

    // R7: read of high port clears pointer
    setPtr(16'h0123);
    portRd("R7 clear returns FF", 8'hF8);
    portRd("R7 ptr zero", 8'hF9);

    // R8: other ports
    setPtr(16'h0040);
    portRd("R8 data port read", 8'hFA);
    portRd("R8 port 00", 8'h00);
    portRd("R8 port F7", 8'hF7);
    portRd("R8 port FB", 8'hFB);
    portWr(8'hFB, 8'hEE);
    portWr(8'h00, 8'hDD);
    portRd("R8 ptr unchanged", 8'hF9);
    setPtr(16'h0040);
    portRd("R8 mem unchanged", 8'hF9);

    // R9: upper pointer bits ignored when indexing
    setPtr(16'h8805);
    portWr(8'hFA, 8'hC3);
    setPtr(16'h0005);
    portRd("R9 alias", 8'hF9);

    // R10: pointer wrap
    setPtr(16'hFFFF);
    portWr(8'hFA, 8'h5A);
    #5 check8("R10 wrap lo", ptrQ[7:0], 8'h00);
    check8("R10 wrap hi", ptrQ[15:8], 8'h00);
    portRd("R10 after wrap", 8'hF9);
    setPtr(16'hFFFF);
    portRd("R10 top byte", 8'hF9);
    portRd("R10 read wrap", 8'hF9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule